// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block supplies the word address that a pipelined synchronous burst SRAM presents to its array. A new starting address is captured on a rising clock edge when one of two active-low strobes is asserted. The processor-side strobe counts only while the chip enable is asserted. The controller-side strobe is always acted on. After capture, a two-bit beat counter steps through the four words of the burst, one step per clock in which the advance input is held low. A static order input chooses an interleaved or a linear wrap-around sequence.

The array address is formed from the captured address. Its upper bits are passed through unchanged and its two low bits are replaced by the beat-adjusted value. A burst-active flag tells the surrounding logic whether a selected access is in progress. A controller strobe seen while the chip enable is deasserted ends the access and clears that flag.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the beat count becomes 0, `burst_active` becomes 0 and the captured address becomes 0, so `arr_addr` reads 0 after reset.
- R2: A low `ctrl_strobe_n` with `ce_n` low at a rising edge captures `addr_in`. From the next cycle `arr_addr` equals `addr_in` and `burst_active` is 1, whatever `proc_strobe_n` is.
- R3: A low `proc_strobe_n` with `ce_n` low captures `addr_in` in the same way as R2. While `ce_n` is high, a low `proc_strobe_n` leaves `arr_addr` and `burst_active` unchanged.
- R4: A low `ctrl_strobe_n` with `ce_n` high clears `burst_active` and the beat count, and keeps the captured address. `arr_addr` then equals the captured address.
- R5: With no strobe taking effect, `burst_active` at 1 and `advance_n` low, the beat count steps by one. While `burst_active` is 0, `advance_n` has no effect on `arr_addr`.
- R6: With no strobe taking effect and `advance_n` high, the beat count and `arr_addr` hold.
- R7: With `interleave` = 1, the two low bits of `arr_addr` are the captured low bits XOR the beat count.
- R8: With `interleave` = 0, the two low bits of `arr_addr` are the captured low bits plus the beat count, modulo 4.
- R9: After four advances from any beat, `arr_addr` is back at the address it started from.
- R10: Bits above bit 1 of `arr_addr` change only on a capture.
- R11: A strobe that takes effect in the middle of a burst wins over `advance_n`. It captures the new address and restarts at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low, gated by `ce_n` |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low, always acted on |
| advance_n | input | 1 | Burst advance, active low |
| interleave | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_in | input | AW | External word address |
| arr_addr | output | AW | Current array word address |
| burst_active | output | 1 | A selected burst is in progress |

## Verification
Bursts are started from every low-bit phase (0 to 3) in both orders. Phases 1 and 3 are where XOR and modulo addition give different sequences, so those starts show the two orders apart. Advance pulses are mixed with held cycles to separate stepping from suspension, and runs of five or more advances show the wrap back to the start. Strobe patterns cover each of these cases:
- processor strobe with the enable asserted and with it deasserted;
- controller strobe with the enable asserted and with it deasserted;
- a restart in the middle of a burst while advance is held low.

Together these separate a gated capture, an ungated capture, a deselect and an ignored strobe. An all-ones base address shows whether a carry from the low bits leaks into the upper bits.

// File: rtl/bseq_pkg.sv
// Package: shared order type and beat arithmetic for the burst address sequencer.
// Assumes the beat counter width is fixed by BEAT_W (a four-beat burst).
package bseq_pkg;
    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    // Low address bits for beat n starting from start_lo, in the chosen order.
    function automatic logic [BEAT_W-1:0] beat_lo(
        input logic [BEAT_W-1:0] start_lo,
        input logic [BEAT_W-1:0] n,
        input order_e            ord
    );
        if (ord == ORD_INTERLEAVE)
            return start_lo ^ n;
        else
            return BEAT_W'(start_lo + n);
    endfunction
endpackage

// File: rtl/bseq_strobe_dec.sv
// Module: strobe decoder. Turns the two address strobes and the chip enable
// into a capture request and a deselect request.
// Assumes all inputs are already synchronous to clk; purely combinational.
module bseq_strobe_dec (
    input  logic ce_n,
    input  logic proc_strobe_n,
    input  logic ctrl_strobe_n,
    output logic start_o,
    output logic stop_o
);
    // Capture when enabled and either strobe is low; deselect on controller strobe when not enabled.
    always_comb begin
        start_o = !ce_n && (!ctrl_strobe_n || !proc_strobe_n);
        stop_o  = ce_n && !ctrl_strobe_n;
    end
endmodule

// File: rtl/bseq_beat_ctr.sv
// Module: beat counter. Holds the wrap-around beat index and the burst-active flag.
// Assumes start_i and stop_i are never both high (the decoder guarantees this).
module bseq_beat_ctr #(
    parameter int CW = bseq_pkg::BEAT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          advance_n,
    output logic [CW-1:0] cnt_o,
    output logic          active_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // Beat index and active flag: reset, restart, deselect, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o    <= '0;
            active_o <= 1'b0;
        end else if (start_i) begin
            cnt_o    <= '0;
            active_o <= 1'b1;
        end else if (stop_i) begin
            cnt_o    <= '0;
            active_o <= 1'b0;
        end else if (active_o && !advance_n) begin
            cnt_o    <= cnt_o + ONE;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (cnt_o == '0 && !active_o)); // R1
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !stop_i && active_o && !advance_n) |=> (cnt_o == CW'($past(cnt_o) + ONE))); // R5
    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !stop_i && advance_n) |=> $stable(cnt_o)); // R6
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_o == '0 && active_o)); // R11
endmodule

// File: rtl/bseq_addr_fmt.sv
// Module: address formatter. Replaces the low bits of the captured address
// with the beat-adjusted value; upper bits pass through.
// Assumes AW >= BW; combinational.
module bseq_addr_fmt #(
    parameter int AW = 21,
    parameter int BW = bseq_pkg::BEAT_W
) (
    input  logic [AW-1:0] base_i,
    input  logic [BW-1:0] cnt_i,
    input  logic          interleave,
    output logic [AW-1:0] addr_o
);
    import bseq_pkg::*;

    logic [BW-1:0] lo;

    // Low bits for the current beat in the selected order.
    always_comb lo = beat_lo(base_i[BW-1:0], cnt_i, order_e'(interleave));

    generate
        if (AW > BW) begin : g_wide
            // Upper bits unchanged, low bits from the beat.
            always_comb addr_o = {base_i[AW-1:BW], lo};
        end else begin : g_narrow
            // Whole address is the beat field.
            always_comb addr_o = lo;
        end
    endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst address sequencer top. Captures a base address on a valid
// strobe and presents the four-beat burst address to the array.
// Assumes synchronous inputs and a static order input during a burst.
module burst_addr_seq #(
    parameter int AW = 21
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          proc_strobe_n,
    input  logic          ctrl_strobe_n,
    input  logic          advance_n,
    input  logic          interleave,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] arr_addr,
    output logic          burst_active
);
    import bseq_pkg::*;

    logic              start, stop;
    logic [AW-1:0]     base_q;
    logic [BEAT_W-1:0] cnt;

    bseq_strobe_dec u_dec (
        .ce_n          (ce_n),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .start_o       (start),
        .stop_o        (stop)
    );

    // Base address register: loads on capture only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (start)
            base_q <= addr_in;
    end

    bseq_beat_ctr #(.CW(BEAT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .stop_i    (stop),
        .advance_n (advance_n),
        .cnt_o     (cnt),
        .active_o  (burst_active)
    );

    bseq_addr_fmt #(.AW(AW), .BW(BEAT_W)) u_fmt (
        .base_i     (base_q),
        .cnt_i      (cnt),
        .interleave (interleave),
        .addr_o     (arr_addr)
    );

    AST_CAPTURE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n && !ce_n) |=> (burst_active && base_q == $past(addr_in))); // R2
    AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && ctrl_strobe_n) |=> ($stable(burst_active) && $stable(base_q))); // R3
    AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !ctrl_strobe_n) |=> (!burst_active && $stable(base_q))); // R4
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start) |=> $stable(arr_addr[AW-1:BEAT_W])); // R10
endmodule

// File: tb/burst_addr_seq_tb.sv
// Bench: behavioural reference model compared with the outputs on every clock.
module burst_addr_seq_tb;
    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          advance_n = 1'b1;
    logic          interleave = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] arr_addr;
    logic          burst_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [AW-1:0] m_base = '0;
    int            m_cnt  = 0;
    bit            m_act  = 1'b0;

    always #4 clk = ~clk;

    burst_addr_seq #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .proc_strobe_n(proc_strobe_n),
        .ctrl_strobe_n(ctrl_strobe_n), .advance_n(advance_n), .interleave(interleave),
        .addr_in(addr_in), .arr_addr(arr_addr), .burst_active(burst_active)
    );

    function automatic logic [AW-1:0] expect_addr();
        logic [1:0] lo;
        lo = m_base[1:0];
        if (interleave) lo = lo ^ 2'(m_cnt);
        else            lo = 2'(int'(lo) + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    // One clock: drive at negedge, update the model at posedge, compare at next negedge.
    task automatic cyc(input bit rst, input bit ce, input bit ps, input bit cs,
                       input bit adv, input bit il, input logic [AW-1:0] a, input string tag);
        logic [AW-1:0] ea;
        rst_n = rst; ce_n = ce; proc_strobe_n = ps; ctrl_strobe_n = cs;
        advance_n = adv; interleave = il; addr_in = a;
        @(posedge clk);
        if (!rst) begin
            m_base = '0; m_cnt = 0; m_act = 1'b0;
        end else if (!ce && (!cs || !ps)) begin
            m_base = a; m_cnt = 0; m_act = 1'b1;
        end else if (ce && !cs) begin
            m_cnt = 0; m_act = 1'b0;
        end else if (m_act && !adv) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        ea = expect_addr();
        checks++;
        if (arr_addr !== ea) begin
            fails++;
            $display("FAIL %s arr_addr actual %h expected %h", tag, arr_addr, ea);
        end
        checks++;
        if (burst_active !== m_act) begin
            fails++;
            $display("FAIL %s burst_active actual %b expected %b", tag, burst_active, m_act);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        repeat (3) cyc(0, 1, 1, 1, 1, 1, '0, "R1");
        cyc(1, 1, 1, 1, 1, 1, '0, "R1");
        // R5 advance ignored while inactive
        repeat (2) cyc(1, 1, 1, 1, 0, 1, 21'h0ABCD, "R5");
        // R2 controller capture, interleaved from phase 1 (R7, R9)
        cyc(1, 0, 1, 0, 1, 1, 21'h12345, "R2");
        for (int i = 0; i < 5; i++) cyc(1, 0, 1, 1, 0, 1, 21'h0, "R7");
        // R6 suspension
        repeat (3) cyc(1, 0, 1, 1, 1, 1, 21'h0, "R6");
        for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, 0, 1, 21'h0, "R9");
        // R8 linear from phase 3 on all-ones upper bits (R10)
        cyc(1, 0, 0, 1, 1, 0, 21'h1FFFFF, "R3");
        for (int i = 0; i < 6; i++) cyc(1, 0, 1, 1, 0, 0, 21'h0, "R8");
        cyc(1, 0, 1, 1, 0, 0, 21'h0, "R10");
        // R3 processor strobe ignored while disabled
        cyc(1, 1, 0, 1, 0, 0, 21'h05555, "R3");
        cyc(1, 1, 0, 1, 1, 0, 21'h0AAAA, "R3");
        // R11 restart mid-burst with advance held low
        cyc(1, 0, 1, 1, 0, 1, 21'h0, "R11");
        cyc(1, 0, 1, 0, 0, 1, 21'h00F02, "R11");
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, 1, 0, 1, 21'h0, "R9");
        cyc(1, 0, 0, 0, 0, 0, 21'h10001, "R11");
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, 1, 0, 0, 21'h0, "R8");
        // R4 deselect, then advance ignored (R5)
        cyc(1, 0, 1, 1, 0, 0, 21'h0, "R5");
        cyc(1, 1, 1, 0, 0, 0, 21'h1ABCD, "R4");
        repeat (2) cyc(1, 1, 1, 1, 0, 1, 21'h0, "R5");
        // R2 capture with both strobes, phase 2 interleaved then linear
        cyc(1, 0, 0, 0, 1, 1, 21'h0C0C2, "R2");
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, 1, 0, (i % 2 == 0), 21'h0, "R7");
        // R1 reset mid-burst
        cyc(0, 0, 1, 1, 0, 1, 21'h0, "R1");
        cyc(1, 1, 1, 1, 1, 1, 21'h0, "R1");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule